// File: doc/BRIEF.md
# HART Receive Character Framer

This block sits behind a HART demodulator and turns its recovered bit stream into bytes. The demodulated line is 1200 baud, and each character uses the 8O1 format: a start bit, eight data bits sent least-significant first, an odd-parity bit and a stop bit, for 11 bit times per character. A clock enable at sixteen times the bit rate paces all timing inside the block. A carrier-detect input, already qualified upstream, gates the whole receiver. While it is low, the line is ignored and any partly received character is dropped.

Each finished character is presented on a byte bus with a one-cycle valid strobe. Parity and stop-bit faults are latched into sticky flags. HART has no end-of-message delimiter, so the block also watches the quiet time after every good character while the carrier stays up. If the next start bit does not arrive within one character time, it latches a gap error. If the carrier drops instead, the message is taken as finished and no gap is reported. All three flags stay set until a clear pulse.

Top module: `hart_char_rx`

## Requirements
- R1: After reset, `byteValid`, `parityErr`, `frameErr` and `gapErr` are 0 and `rxByte` is 0x00.
- R2: A character is one low start bit, 8 data bits with the least-significant bit first, one parity bit and one stop bit, each bit 16 ticks long. Each bit is sampled once near its middle, and the assembled byte appears on `rxByte` when the stop bit is sampled.
- R3: A start bit is accepted only on a high-to-low transition of `rxBit` that is still low half a bit later. A low pulse shorter than half a bit produces no byte.
- R4: `byteValid` is high for exactly one clock cycle per received character, including characters with a parity or stop-bit fault.
- R5: `parityErr` is set when the number of ones across the 8 data bits and the parity bit is even. The byte is still delivered.
- R6: `frameErr` is set when the stop bit samples low.
- R7: After a character with a high stop bit and correct parity, `gapErr` is set if the carrier stays high and no new start edge arrives within 11 bit times after the end of that stop bit. An idle gap of 10 bit times does not set it, and an idle gap of 12 bit times does.
- R8: If `carrierOk` falls after a character, the gap timer is abandoned and `gapErr` is not set for that idle period, even after the carrier returns.
- R9: While `carrierOk` is low, `rxBit` is ignored: no byte is produced. A character cut short by a carrier drop is discarded, and the next full character is received correctly.
- R10: `parityErr`, `frameErr` and `gapErr` stay set until `clearErr` is high for a cycle. On that cycle all three return to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Clock enable at 16 times the bit rate, one cycle wide |
| rxBit | input | 1 | Demodulated serial data, idle high |
| carrierOk | input | 1 | Qualified carrier present |
| clearErr | input | 1 | Pulse that clears the sticky error flags |
| rxByte | output | 8 | Last received data byte |
| byteValid | output | 1 | One-cycle strobe marking a new byte on `rxByte` |
| parityErr | output | 1 | Sticky parity fault flag |
| frameErr | output | 1 | Sticky stop-bit fault flag |
| gapErr | output | 1 | Sticky inter-character gap fault flag |

## Verification
Bit-phase or bit-index faults show up on the byte bus at the very next character. They appear as a shifted or rotated byte, a lost byte, or a spurious parity or stop fault, all within one character time of the fault. A gap timer that is off in length or arming separates the 10-bit and 12-bit idle cases. A timer that ignores carrier loss sets `gapErr` during the long carrier-off idle, about 11 bit times after the drop. Errors in carrier gating show up as extra bytes while the carrier is low, or as a wrong byte after a character cut short.

// File: rtl/hcr_pkg.sv
package hcr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } rxState_e;

  // strobes from the control FSM to the datapath, each one cycle wide
  typedef struct packed {
    logic clearAcc;    // start bit confirmed, reset the accumulators
    logic shiftBit;    // mid-sample of a data bit
    logic takeParity;  // mid-sample of the parity bit
    logic takeStop;    // mid-sample of the stop bit
  } rxStrobe_t;

endpackage

// File: rtl/hcr_ctrl.sv
module hcr_ctrl
  import hcr_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick16,
  input  logic      rxBit,
  input  logic      carrierOk,
  output rxStrobe_t strobe,
  output logic      startSeen
);

  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVERSAMPLE - 1);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(DATA_BITS - 1);

  rxState_e         state;
  logic [CNT_W-1:0] phaseCnt;
  logic [IDX_W-1:0] bitIdx;
  logic             prevBit;
  logic             live;
  logic             fullPoint;
  logic             halfPoint;

  assign live      = carrierOk && tick16;
  assign fullPoint = (phaseCnt == FULL_LAST);
  assign halfPoint = (phaseCnt == HALF_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      bitIdx   <= '0;
      prevBit  <= 1'b1;
    end else if (!carrierOk) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      bitIdx   <= '0;
      prevBit  <= 1'b1;
    end else if (tick16) begin
      prevBit <= rxBit;
      unique case (state)
        ST_IDLE: begin
          if (prevBit && !rxBit) begin
            state    <= ST_START;
            phaseCnt <= '0;
          end
        end
        ST_START: begin
          if (halfPoint) begin
            phaseCnt <= '0;
            bitIdx   <= '0;
            state    <= rxBit ? ST_IDLE : ST_DATA;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (fullPoint) begin
            phaseCnt <= '0;
            bitIdx   <= bitIdx + 1'b1;
            if (bitIdx == IDX_LAST) state <= ST_PARITY;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        ST_PARITY: begin
          if (fullPoint) begin
            phaseCnt <= '0;
            state    <= ST_STOP;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (fullPoint) begin
            phaseCnt <= '0;
            state    <= ST_IDLE;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.clearAcc   = live && (state == ST_START)  && halfPoint && !rxBit;
    strobe.shiftBit   = live && (state == ST_DATA)   && fullPoint;
    strobe.takeParity = live && (state == ST_PARITY) && fullPoint;
    strobe.takeStop   = live && (state == ST_STOP)   && fullPoint;
    startSeen         = live && (state == ST_IDLE)   && prevBit && !rxBit;
  end

  // R2: the datapath never gets two sampling strobes in one cycle
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.clearAcc, strobe.shiftBit, strobe.takeParity, strobe.takeStop}));

  // R3: a character only begins from a low line seen with the carrier up
  a_r3_start_from_low: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && $past(state) == ST_IDLE) |-> $past(!rxBit && carrierOk));

  // R9: a missing carrier leaves the receiver idle on the next cycle
  a_r9_idle_without_carrier: assert property (@(posedge clk) disable iff (!rstN)
    !carrierOk |=> (state == ST_IDLE));

endmodule

// File: rtl/hcr_dpath.sv
module hcr_dpath
  import hcr_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxBit,
  input  logic                 clearErr,
  input  rxStrobe_t            strobe,
  output logic [DATA_BITS-1:0] rxByte,
  output logic                 byteValid,
  output logic                 parityErr,
  output logic                 frameErr,
  output logic                 charGood
);

  logic [DATA_BITS-1:0] shiftReg;
  logic                 parAcc;
  logic                 parityOk;
  logic                 setParity;
  logic                 setFrame;

  assign setParity = strobe.takeStop && !parityOk;
  assign setFrame  = strobe.takeStop && !rxBit;
  assign charGood  = strobe.takeStop && rxBit && parityOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
      parityOk <= 1'b1;
    end else begin
      if (strobe.clearAcc) begin
        parAcc <= 1'b0;
      end else if (strobe.shiftBit) begin
        shiftReg <= {rxBit, shiftReg[DATA_BITS-1:1]};
        parAcc   <= parAcc ^ rxBit;
      end
      if (strobe.takeParity) parityOk <= parAcc ^ rxBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte    <= '0;
      byteValid <= 1'b0;
      parityErr <= 1'b0;
      frameErr  <= 1'b0;
    end else begin
      byteValid <= strobe.takeStop;
      if (strobe.takeStop) rxByte <= shiftReg;
      parityErr <= clearErr ? 1'b0 : (parityErr || setParity);
      frameErr  <= clearErr ? 1'b0 : (frameErr || setFrame);
    end
  end

  // R4: the valid strobe never stretches over two cycles
  a_r4_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);

  // R5: a parity fault persists until cleared
  a_r5_parity_hold: assert property (@(posedge clk) disable iff (!rstN)
    (parityErr && !clearErr) |=> parityErr);

  // R10: a clear pulse wins over any fault in the same cycle
  a_r10_clear_flags: assert property (@(posedge clk) disable iff (!rstN)
    clearErr |=> (!parityErr && !frameErr));

endmodule

// File: rtl/hcr_gap.sv
module hcr_gap #(
  parameter int OVERSAMPLE = 16,
  parameter int GAP_BITS   = 11
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick16,
  input  logic carrierOk,
  input  logic charGood,
  input  logic startSeen,
  input  logic clearErr,
  output logic gapErr
);

  // the timer starts at the stop-bit mid-sample, half a bit before the character ends
  localparam int LIMIT = GAP_BITS * OVERSAMPLE + OVERSAMPLE / 2;
  localparam int TW    = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] TIMER_LAST = TW'(LIMIT - 1);

  logic          armed;
  logic [TW-1:0] timer;
  logic          expire;

  assign expire = carrierOk && armed && tick16 && !startSeen && (timer == TIMER_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
      timer <= '0;
    end else if (!carrierOk) begin
      armed <= 1'b0;
      timer <= '0;
    end else if (charGood) begin
      armed <= 1'b1;
      timer <= '0;
    end else if (armed && tick16) begin
      if (startSeen || expire) begin
        armed <= 1'b0;
        timer <= '0;
      end else begin
        timer <= timer + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gapErr <= 1'b0;
    else       gapErr <= clearErr ? 1'b0 : (gapErr || expire);
  end

  // R8: losing the carrier disarms the timer
  a_r8_disarm_on_drop: assert property (@(posedge clk) disable iff (!rstN)
    !carrierOk |=> !armed);

  // R7: a gap fault only appears while the carrier is up
  a_r7_gap_needs_carrier: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gapErr) |-> $past(carrierOk));

  // R10: the gap flag holds until cleared
  a_r10_gap_hold: assert property (@(posedge clk) disable iff (!rstN)
    (gapErr && !clearErr) |=> gapErr);

endmodule

// File: rtl/hart_char_rx.sv
module hart_char_rx
  import hcr_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8,
  parameter int GAP_BITS   = 11
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tick16,
  input  logic                 rxBit,
  input  logic                 carrierOk,
  input  logic                 clearErr,
  output logic [DATA_BITS-1:0] rxByte,
  output logic                 byteValid,
  output logic                 parityErr,
  output logic                 frameErr,
  output logic                 gapErr
);

  rxStrobe_t strobe;
  logic      startSeen;
  logic      charGood;

  hcr_ctrl #(
    .OVERSAMPLE(OVERSAMPLE),
    .DATA_BITS (DATA_BITS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tick16   (tick16),
    .rxBit    (rxBit),
    .carrierOk(carrierOk),
    .strobe   (strobe),
    .startSeen(startSeen)
  );

  hcr_dpath #(
    .DATA_BITS(DATA_BITS)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .rxBit    (rxBit),
    .clearErr (clearErr),
    .strobe   (strobe),
    .rxByte   (rxByte),
    .byteValid(byteValid),
    .parityErr(parityErr),
    .frameErr (frameErr),
    .charGood (charGood)
  );

  hcr_gap #(
    .OVERSAMPLE(OVERSAMPLE),
    .GAP_BITS  (GAP_BITS)
  ) u_gap (
    .clk      (clk),
    .rstN     (rstN),
    .tick16   (tick16),
    .carrierOk(carrierOk),
    .charGood (charGood),
    .startSeen(startSeen),
    .clearErr (clearErr),
    .gapErr   (gapErr)
  );

endmodule

// File: tb/hart_char_rx_tb.sv
module hart_char_rx_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TICKS_PER_BIT = 16;
  localparam int WATCHDOG_CYCLES = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick16;
  logic       rxBit = 1'b1;
  logic       carrierOk = 1'b0;
  logic       clearErr = 1'b0;
  logic [7:0] rxByte;
  logic       byteValid;
  logic       parityErr;
  logic       frameErr;
  logic       gapErr;

  logic [1:0] tickDiv = '0;
  int checks = 0;
  int errors = 0;
  int gotCount = 0;
  int expCount = 0;
  logic [7:0] expQ[$];

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) tickDiv <= tickDiv + 2'd1;
  assign tick16 = (tickDiv == 2'd3);

  hart_char_rx u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .tick16   (tick16),
    .rxBit    (rxBit),
    .carrierOk(carrierOk),
    .clearErr (clearErr),
    .rxByte   (rxByte),
    .byteValid(byteValid),
    .parityErr(parityErr),
    .frameErr (frameErr),
    .gapErr   (gapErr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // monitor: every valid strobe pops one expected byte
  always @(negedge clk) begin
    if (rstN && byteValid) begin
      gotCount++;
      if (expQ.size() == 0) begin
        check(1'b0, "R4/R9 unexpected byte", rxByte, 0);
      end else begin
        logic [7:0] e;
        e = expQ.pop_front();
        check(rxByte == e, "R2 byte value", rxByte, e);
      end
    end
  end

  task automatic waitTick();
    do @(negedge clk); while (!tick16);
  endtask

  task automatic waitBits(input int n);
    repeat (n * TICKS_PER_BIT) waitTick();
  endtask

  task automatic driveBit(input logic b);
    rxBit = b;
    waitBits(1);
  endtask

  // driver: full 8O1 character, optionally corrupted, then idle-high bits
  task automatic sendChar(input logic [7:0] d, input bit badPar, input bit badStop,
                          input bit expectIt, input int idleBits);
    logic p;
    if (expectIt) begin
      expQ.push_back(d);
      expCount++;
    end
    p = ~(^d) ^ badPar;
    driveBit(1'b0);
    for (int i = 0; i < 8; i++) driveBit(d[i]);
    driveBit(p);
    driveBit(~badStop);
    rxBit = 1'b1;
    if (idleBits > 0) waitBits(idleBits);
  endtask

  task automatic pulseClear();
    @(negedge clk);
    clearErr = 1'b1;
    @(negedge clk);
    clearErr = 1'b0;
    @(negedge clk);
  endtask

  task automatic checkCounts(input string req);
    check(gotCount == expCount, req, gotCount, expCount);
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset values
    check(byteValid == 1'b0, "R1 byteValid", byteValid, 0);
    check({parityErr, frameErr, gapErr} == 3'b000, "R1 flags", {parityErr, frameErr, gapErr}, 0);
    check(rxByte == 8'h00, "R1 rxByte", rxByte, 0);
    rstN = 1'b1;
    @(negedge clk);
    carrierOk = 1'b1;
    waitBits(2);

    // R2 R4: clean characters of several patterns
    sendChar(8'h00, 0, 0, 1, 2);  checkCounts("R4 count 00");
    sendChar(8'hFF, 0, 0, 1, 2);  checkCounts("R4 count FF");
    sendChar(8'hA5, 0, 0, 1, 2);  checkCounts("R4 count A5");
    sendChar(8'h3C, 0, 0, 1, 2);  checkCounts("R4 count 3C");
    sendChar(8'h01, 0, 0, 1, 2);  checkCounts("R2 lsb first 01");
    sendChar(8'h80, 0, 0, 1, 2);  checkCounts("R2 lsb first 80");
    check({parityErr, frameErr} == 2'b00, "R5/R6 clean flags", {parityErr, frameErr}, 0);

    // R5: parity fault, byte still delivered; R10 sticky across a good char
    sendChar(8'h5A, 1, 0, 1, 2);
    checkCounts("R5 byte delivered on parity fault");
    check(parityErr == 1'b1, "R5 parityErr set", parityErr, 1);
    check(frameErr == 1'b0, "R6 no frameErr on parity fault", frameErr, 0);
    sendChar(8'h12, 0, 0, 1, 2);
    check(parityErr == 1'b1, "R10 parityErr sticky", parityErr, 1);
    pulseClear();
    check(parityErr == 1'b0, "R10 parityErr cleared", parityErr, 0);

    // R6: stop bit low
    sendChar(8'h33, 0, 1, 1, 2);
    checkCounts("R6 byte delivered on stop fault");
    check(frameErr == 1'b1, "R6 frameErr set", frameErr, 1);
    check(parityErr == 1'b0, "R5 no parityErr on stop fault", parityErr, 0);
    pulseClear();
    check(frameErr == 1'b0, "R10 frameErr cleared", frameErr, 0);

    // R3: short low glitch is not a start bit
    rxBit = 1'b0;
    repeat (4) waitTick();
    rxBit = 1'b1;
    waitBits(2);
    checkCounts("R3 glitch gives no byte");
    sendChar(8'h6E, 0, 0, 1, 2);
    checkCounts("R3 good char after glitch");
    check(frameErr == 1'b0, "R3 no frameErr after glitch", frameErr, 0);

    // R7: gap timing with the carrier held up
    carrierOk = 1'b0;
    waitBits(1);
    carrierOk = 1'b1;
    waitBits(1);
    pulseClear();
    sendChar(8'hC5, 0, 0, 1, 10);
    sendChar(8'h4B, 0, 0, 1, 2);
    check(gapErr == 1'b0, "R7 10-bit gap accepted", gapErr, 0);
    waitBits(10);
    check(gapErr == 1'b1, "R7 12-bit gap flagged", gapErr, 1);
    pulseClear();
    check(gapErr == 1'b0, "R10 gapErr cleared", gapErr, 0);

    // R8: carrier drop after a character suppresses the gap fault
    sendChar(8'h9D, 0, 0, 1, 0);
    carrierOk = 1'b0;
    waitBits(20);
    check(gapErr == 1'b0, "R8 no gap after carrier drop", gapErr, 0);
    carrierOk = 1'b1;
    waitBits(20);
    check(gapErr == 1'b0, "R8 no gap after carrier return", gapErr, 0);

    // R9: line ignored with no carrier
    carrierOk = 1'b0;
    sendChar(8'h77, 0, 0, 0, 2);
    checkCounts("R9 no byte without carrier");
    check({parityErr, frameErr, gapErr} == 3'b000, "R9 no flags without carrier",
          {parityErr, frameErr, gapErr}, 0);
    carrierOk = 1'b1;
    waitBits(2);

    // R9: character cut short by a carrier drop is discarded
    driveBit(1'b0);
    driveBit(1'b1);
    driveBit(1'b0);
    driveBit(1'b1);
    carrierOk = 1'b0;
    rxBit = 1'b1;
    waitBits(1);
    carrierOk = 1'b1;
    waitBits(12);
    checkCounts("R9 partial char discarded");
    sendChar(8'hC3, 0, 0, 1, 2);
    checkCounts("R9 recovery char");
    check(frameErr == 1'b0, "R9 no frameErr after abort", frameErr, 0);

    waitBits(1);
    check(expQ.size() == 0, "R4 all expected bytes seen", expQ.size(), 0);
    finishRun();
  end

endmodule